// File: doc/BRIEF.md
# Quadrature Encoder Emulation Generator

This block turns an absolute angle word into the outputs of an incremental encoder. These outputs are two channels in quadrature, a once-per-turn index marker and a direction line. The angle word arrives each clock, aligned to its most significant bit. A two-bit select picks how many of its upper bits are active: 10, 12, 14 or 16. Downstream motor-control logic can count these outputs in the same way it counts a real optical encoder.

Internally the block keeps a tracked position in units of the active least significant bit. Each clock it moves that position by at most one count toward the incoming angle, taking the shorter way around the circle. As a result the channels never skip a quadrature state, even when the angle jumps. A validity input freezes the whole generator while the sensor signals are not trustworthy. After reset, and after any change of resolution, the first valid cycle loads the tracked position directly without stepping.

Top module: `quad_emu`

## Requirements
- R1: The select `res_sel` chooses the active width: 2'b00 gives 10 bits, 2'b10 gives 12, 2'b01 gives 14 and 2'b11 gives 16. The active angle is the upper width bits of `angle`.
- R2: Channels A and B follow the two low bits p of the tracked position in Gray order. p=0 gives A,B=0,0; p=1 gives 0,1; p=2 gives 1,1; p=3 gives 1,0. The outputs show the tracked position one clock after it is updated.
- R3: The marker is high exactly when the tracked position is zero. A and B are then both low.
- R4: Direction goes high when the tracked position steps up and low when it steps down. It holds its value when the position does not step. It resets low.
- R5: The tracked position moves at most one count per clock, in the direction of the shorter arc modulo 2^width. A difference of exactly half a turn steps downward. The visible A,B pair therefore changes by at most one bit per clock.
- R6: While `ang_valid` is low, the tracked position, the resolution in use, A, B, the marker and direction all hold.
- R7: Reset clears A, B, the marker and direction to low and leaves the block unlocked. The first valid cycle then loads the active angle directly, without stepping and without changing direction.
- R8: A change of `res_sel` seen in a valid cycle unlocks the block for one cycle. The next valid cycle reloads the position at the new width, and direction keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_sel | input | 2 | Resolution select, bit 0 first select, bit 1 second select |
| angle | input | 16 | Absolute angle, MSB-aligned |
| ang_valid | input | 1 | Sensor signals are healthy |
| enc_a | output | 1 | Quadrature channel A |
| enc_b | output | 1 | Quadrature channel B |
| enc_z | output | 1 | Once-per-turn marker |
| enc_dir | output | 1 | High while stepping up |

## Verification
A corrupted tracked position shows at A and B two clocks after the fault. It appears either as a two-bit jump of the channel pair or as a Gray step against the direction line. A wrong zero decode shows as a marker that is high while A or B is high. A broken validity gate shows as output motion two clocks after `ang_valid` falls. A wrong shortest-path or half-turn rule shows in the direction line within two clocks of the angle jump.

// File: rtl/quad_emu_pkg.sv
package quad_emu_pkg;

  // rank of the selected width: 0 -> narrowest, 3 -> widest
  function automatic logic [1:0] res_rank(input logic [1:0] sel);
    return {sel[0], sel[1]};
  endfunction

  // Gray pattern {A,B} for the two low position bits
  function automatic logic [1:0] gray_ab(input logic [1:0] p);
    return {p[1], p[1] ^ p[0]};
  endfunction

endpackage

// File: rtl/quad_res_map.sv
module quad_res_map #(
  parameter int MIN_W  = 10,
  parameter int STEP_W = 2,
  parameter int ANG_W  = MIN_W + 3 * STEP_W
) (
  input  logic [1:0]       res_sel,
  input  logic [ANG_W-1:0] angle,
  output logic [ANG_W-1:0] target,
  output logic [ANG_W-1:0] mask
);
  import quad_emu_pkg::*;

  localparam int NUM_RES = 4;

  logic [ANG_W-1:0] tgt_opt  [NUM_RES];
  logic [ANG_W-1:0] mask_opt [NUM_RES];

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    localparam int SH = ANG_W - (MIN_W + STEP_W * r);
    assign tgt_opt[r]  = angle >> SH;
    assign mask_opt[r] = {ANG_W{1'b1}} >> SH;
  end

  assign target = tgt_opt[res_rank(res_sel)];
  assign mask   = mask_opt[res_rank(res_sel)];

endmodule

// File: rtl/quad_tracker.sv
module quad_tracker #(
  parameter int ANG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [1:0]       res_sel,
  input  logic [ANG_W-1:0] target,
  input  logic [ANG_W-1:0] mask,
  output logic [ANG_W-1:0] pos,
  output logic             locked,
  output logic             dir
);
  logic [ANG_W-1:0] pos_q, diff, pos_up, pos_dn, half_m;
  logic [1:0]       res_q;
  logic             locked_q, dir_q, move, back;

  always_comb begin
    diff   = (target - pos_q) & mask;
    half_m = mask >> 1;
    move   = |diff;
    back   = |(diff & ~half_m);
    pos_up = (pos_q + ANG_W'(1)) & mask;
    pos_dn = (pos_q - ANG_W'(1)) & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      res_q    <= '0;
      locked_q <= 1'b0;
      dir_q    <= 1'b0;
    end else if (valid) begin
      if (res_sel != res_q) begin
        locked_q <= 1'b0;
        res_q    <= res_sel;
      end else if (!locked_q) begin
        pos_q    <= target;
        locked_q <= 1'b1;
      end else if (move) begin
        pos_q <= back ? pos_dn : pos_up;
        dir_q <= !back;
      end
    end
  end

  assign pos    = pos_q;
  assign locked = locked_q;
  assign dir    = dir_q;

endmodule

// File: rtl/quad_out.sv
module quad_out #(
  parameter int ANG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ANG_W-1:0] pos,
  input  logic             locked,
  input  logic             dir_in,
  output logic             enc_a,
  output logic             enc_b,
  output logic             enc_z,
  output logic             enc_dir,
  output logic             live
);
  import quad_emu_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_a   <= 1'b0;
      enc_b   <= 1'b0;
      enc_z   <= 1'b0;
      enc_dir <= 1'b0;
      live    <= 1'b0;
    end else begin
      live    <= locked;
      enc_dir <= dir_in;
      if (locked) begin
        {enc_a, enc_b} <= gray_ab(pos[1:0]);
        enc_z          <= (pos == '0);
      end else begin
        enc_a <= 1'b0;
        enc_b <= 1'b0;
        enc_z <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/quad_emu.sv
module quad_emu #(
  parameter int MIN_W  = 10,
  parameter int STEP_W = 2,
  localparam int ANG_W = MIN_W + 3 * STEP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       res_sel,
  input  logic [ANG_W-1:0] angle,
  input  logic             ang_valid,
  output logic             enc_a,
  output logic             enc_b,
  output logic             enc_z,
  output logic             enc_dir
);
  logic [ANG_W-1:0] target, mask, pos;
  logic             locked, dir, out_live;

  quad_res_map #(.MIN_W(MIN_W), .STEP_W(STEP_W), .ANG_W(ANG_W)) u_map (
    .res_sel(res_sel), .angle(angle), .target(target), .mask(mask)
  );

  quad_tracker #(.ANG_W(ANG_W)) u_trk (
    .clk(clk), .rst(rst), .valid(ang_valid), .res_sel(res_sel),
    .target(target), .mask(mask), .pos(pos), .locked(locked), .dir(dir)
  );

  quad_out #(.ANG_W(ANG_W)) u_out (
    .clk(clk), .rst(rst), .pos(pos), .locked(locked), .dir_in(dir),
    .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z), .enc_dir(enc_dir),
    .live(out_live)
  );

endmodule

// File: rtl/quad_emu_chk.sv
module quad_emu_chk (
  input logic clk,
  input logic rst,
  input logic valid,
  input logic a,
  input logic b,
  input logic z,
  input logic dir,
  input logic live
);
  logic [1:0] age;
  logic [1:0] idx;

  assign idx = {a, a ^ b};

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!a && !b && !z && !dir));

  assert_marker_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
    z |-> (!a && !b));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    (live && $past(live)) |-> ($countones({a, b} ^ $past({a, b})) <= 1));

  assert_dir_up_R4: assert property (@(posedge clk) disable iff (rst)
    (live && $past(live) && (idx == $past(idx) + 2'd1)) |-> dir);

  assert_dir_down_R4: assert property (@(posedge clk) disable iff (rst)
    (live && $past(live) && (idx == $past(idx) - 2'd1)) |-> !dir);

  assert_hold_invalid_R6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(valid, 2)) |-> $stable({a, b, z, dir}));

endmodule

bind quad_emu quad_emu_chk u_chk (
  .clk(clk), .rst(rst), .valid(ang_valid), .a(enc_a), .b(enc_b),
  .z(enc_z), .dir(enc_dir), .live(out_live)
);

// File: tb/test_quad_emu.sv
module test_quad_emu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  res_sel = 2'b00;
  logic [15:0] angle = '0;
  logic        ang_valid = 1'b0;
  logic        enc_a, enc_b, enc_z, enc_dir;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  quad_emu i_quad_emu (
    .clk(clk), .rst(rst), .res_sel(res_sel), .angle(angle),
    .ang_valid(ang_valid), .enc_a(enc_a), .enc_b(enc_b),
    .enc_z(enc_z), .enc_dir(enc_dir)
  );

  // {res_sel, angle, expected {A, B, marker, dir}}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 16'h0000, 4'b0010},
    {2'd0, 16'h0040, 4'b0101},
    {2'd0, 16'h00C0, 4'b1001},
    {2'd0, 16'h0080, 4'b1100},
    {2'd0, 16'hFFC0, 4'b1000},
    {2'd0, 16'h0000, 4'b0011},
    {2'd2, 16'h0050, 4'b0101},
    {2'd2, 16'h0040, 4'b0000},
    {2'd3, 16'hFFFE, 4'b1100},
    {2'd3, 16'h0001, 4'b0101},
    {2'd1, 16'h0000, 4'b0011},
    {2'd1, 16'h0004, 4'b0101}
  };

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got {a,b,z,dir}=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {enc_a, enc_b, enc_z, enc_dir};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset state", outs(), 4'b0000);
    // first valid cycle loads count 2 directly, no steps
    ang_valid = 1'b1;
    angle = 16'h0080;
    @(negedge clk);
    @(negedge clk);
    chk("R7 direct load", outs(), 4'b1100);

    // vector walk: R1 widths, R2 Gray, R3 marker, R4 dir, R5 wrap, R8 relock
    for (int i = 0; i < NV; i++) begin
      res_sel = VEC[i][21:20];
      angle   = VEC[i][19:4];
      repeat (8) @(negedge clk);
      chk("R1 R2 R3 R4 R5 R8 vector", outs(), VEC[i][3:0]);
    end

    // R5: jump of three counts walks every state
    res_sel = 2'd0;
    angle = 16'h0000;
    repeat (8) @(negedge clk);
    angle = 16'h00C0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 step 1", outs(), 4'b0101);
    @(negedge clk);
    chk("R5 step 2", outs(), 4'b1101);
    @(negedge clk);
    chk("R5 step 3", outs(), 4'b1001);
    @(negedge clk);
    chk("R5 settled", outs(), 4'b1001);

    // R6: invalid input freezes outputs and direction
    ang_valid = 1'b0;
    angle = 16'h0040;
    repeat (10) @(negedge clk);
    chk("R6 hold while invalid", outs(), 4'b1001);
    ang_valid = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 resume", outs(), 4'b0100);

    // R5: exact half turn steps downward
    angle = 16'h0080;
    repeat (8) @(negedge clk);
    chk("R4 up to count 2", outs(), 4'b1101);
    angle = 16'h8080;
    repeat (4) @(negedge clk);
    chk("R5 half turn goes down", {3'b000, enc_dir}, 4'b0000);

    // R7: reset in the middle of stepping
    rst = 1'b1;
    @(negedge clk);
    chk("R7 reset mid-run", outs(), 4'b0000);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule